// File: doc/BRIEF.md
# Dual-Mode Watchdog and Interval Timer

This block is a tick-driven counter that serves either as a system watchdog or as a plain periodic timer. Software selects the mode and interval through a single byte-wide write port. In watchdog mode the count must be restarted with an ordered pair of key writes before it expires. If it is not, the block raises a one-cycle reset request and starts counting again. In timer mode each expiry raises a one-cycle interrupt pulse and the count wraps. Timer mode can be stopped at any time. Watchdog mode cannot be left again until the block is reset.

Each write carries three fields. Bits [7:4] hold the service key. Bits [3:2] hold the mode, where 00 and 01 mean idle, 10 means watchdog and 11 means timer. Bits [1:0] hold the interval select. The expiry count is N = 2^(BASE_SHIFT + STEP_SHIFT*sel). With the defaults (3 and 2) this gives 8, 32, 128 or 512 ticks. The counter advances only in cycles where tick_i is high.

Top module: `wdt_dual`

## Requirements
- R1: While rst_ni is low and directly after reset, wdt_rst_o and tmr_irq_o are 0 and the mode is idle.
- R2: With mode 00 or 01 the counter is held at zero and neither output ever pulses.
- R3: In mode 11, tmr_irq_o pulses high for one cycle on every Nth tick and wdt_rst_o stays 0.
- R4: In mode 10 without service, wdt_rst_o pulses high for one cycle on the Nth tick, the count restarts from zero, and the next pulse follows N ticks later. tmr_irq_o stays 0.
- R5: A write with key 0x5 (bits [7:4]) directly after a write with key 0xA restarts the count from zero. The following expiry therefore falls N ticks after that write. A repeated 0xA keeps the sequence armed.
- R6: A key-0x5 write that does not directly follow a key-0xA write has no effect on the count. After an 0xA write, any write with a key other than 0x5 or 0xA discards the armed state.
- R7: Once in mode 10, writes to the mode or interval fields are ignored, including writes that select idle. The expiry schedule is unchanged.
- R8: In mode 11, writing an idle mode stops the timer. Writing mode 11 again restarts the count from zero.
- R9: The counter advances only in cycles with tick_i high. With tick_i low, no expiry occurs and the count is held.
- R10: An accepted write that changes the mode or the interval restarts the count from zero. The first expiry falls N ticks after that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one tick per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Key [7:4], mode [3:2], interval [1:0] |
| wdt_rst_o | output | 1 | One-cycle reset request on watchdog expiry |
| tmr_irq_o | output | 1 | One-cycle interrupt on timer expiry |

## Verification
The assertions assume that a write and a tick in the same cycle are resolved in favour of the write's restart. They also assume the interval cannot change under a running count without a restart, so the count always stays below the selected limit. The stimulus writes at most one byte per cycle and changes inputs only on the falling edge. It places every service or lock-test write well before the next due expiry, so each predicted pulse edge is computed from the last restart alone.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  typedef enum logic [1:0] {
    MODE_IDLE0 = 2'b00,
    MODE_IDLE1 = 2'b01,
    MODE_WDG   = 2'b10,
    MODE_TMR   = 2'b11
  } wdt_mode_e;

  localparam int KEY_W = 4;
  localparam logic [KEY_W-1:0] KEY_ARM  = 4'hA;
  localparam logic [KEY_W-1:0] KEY_FIRE = 4'h5;
endpackage

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             svc_o
);
  logic armed_q;

  // every write re-evaluates the arm state: only 0xA keeps or sets it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      armed_q <= 1'b0;
    else if (wr_en_i) armed_q <= (key_i == KEY_ARM);
  end

  assign svc_o = wr_en_i && armed_q && (key_i == KEY_FIRE);

  AST_SVC_DISARMS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    svc_o |=> !armed_q); // R6
  AST_ARM_ON_KEY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && key_i == KEY_ARM) |=> armed_q); // R5
endmodule

// File: rtl/wdt_mode_ctl.sv
module wdt_mode_ctl
  import wdt_pkg::*;
#(
  parameter int IVL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [1:0]       mode_wr_i,
  input  logic [IVL_W-1:0] ivl_wr_i,
  output wdt_mode_e        mode_o,
  output logic [IVL_W-1:0] ivl_o,
  output logic             cfg_chg_o
);
  wdt_mode_e        mode_q;
  logic [IVL_W-1:0] ivl_q;
  logic             accept;

  assign accept    = wr_en_i && (mode_q != MODE_WDG);
  assign cfg_chg_o = accept && ((mode_wr_i != mode_q) || (ivl_wr_i != ivl_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE0;
      ivl_q  <= '0;
    end else if (accept) begin
      mode_q <= wdt_mode_e'(mode_wr_i);
      ivl_q  <= ivl_wr_i;
    end
  end

  assign mode_o = mode_q;
  assign ivl_o  = ivl_q;

  AST_WDG_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_WDG) |=> (mode_q == MODE_WDG) && $stable(ivl_q)); // R7
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int IVL_W      = 2,
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 2,
  parameter int CNT_W      = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  wdt_mode_e        mode_i,
  input  logic [IVL_W-1:0] ivl_i,
  input  logic             clr_i,
  output logic             wdt_rst_o,
  output logic             tmr_irq_o
);
  localparam int NUM_SEL = 1 << IVL_W;

  logic [CNT_W-1:0] lim_tbl [NUM_SEL];
  logic [CNT_W-1:0] lim, cnt_q;
  logic active, hit, rst_q, irq_q;

  for (genvar g = 0; g < NUM_SEL; g++) begin : g_lim
    assign lim_tbl[g] = CNT_W'(1) << (BASE_SHIFT + STEP_SHIFT * g);
  end

  assign lim    = lim_tbl[ivl_i];
  assign active = (mode_i == MODE_WDG) || (mode_i == MODE_TMR);
  assign hit    = active && tick_i && !clr_i && (cnt_q == lim - 1'b1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      rst_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (!active || clr_i) cnt_q <= '0;
      else if (hit)         cnt_q <= '0;
      else if (tick_i)      cnt_q <= cnt_q + 1'b1;
      rst_q <= hit && (mode_i == MODE_WDG);
      irq_q <= hit && (mode_i == MODE_TMR);
    end
  end

  assign wdt_rst_o = rst_q;
  assign tmr_irq_o = irq_q;

  AST_CNT_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < lim); // R3
  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |=> cnt_q == '0); // R2
  AST_TICK_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active && !tick_i && !clr_i) |=> $stable(cnt_q)); // R9
  AST_CLR_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R5
  AST_RST_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wdt_rst_o |=> !wdt_rst_o); // R4
  AST_IRQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_irq_o |=> !tmr_irq_o); // R3
  AST_OUT_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wdt_rst_o && tmr_irq_o)); // R3
endmodule

// File: rtl/wdt_dual.sv
module wdt_dual
  import wdt_pkg::*;
#(
  parameter int IVL_W      = 2,
  parameter int BASE_SHIFT = 3,
  parameter int STEP_SHIFT = 2,
  localparam int WR_W      = KEY_W + 2 + IVL_W
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            tick_i,
  input  logic            wr_en_i,
  input  logic [WR_W-1:0] wr_data_i,
  output logic            wdt_rst_o,
  output logic            tmr_irq_o
);
  localparam int NUM_SEL = 1 << IVL_W;
  localparam int CNT_W   = BASE_SHIFT + STEP_SHIFT * (NUM_SEL - 1) + 1;

  logic [KEY_W-1:0] key;
  logic [1:0]       mode_wr;
  logic [IVL_W-1:0] ivl_wr, ivl;
  wdt_mode_e        mode;
  logic             svc, cfg_chg, clr;

  assign key     = wr_data_i[WR_W-1 -: KEY_W];
  assign mode_wr = wr_data_i[IVL_W +: 2];
  assign ivl_wr  = wr_data_i[IVL_W-1:0];

  wdt_key_seq u_key (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_en_i(wr_en_i),
    .key_i  (key),
    .svc_o  (svc)
  );

  wdt_mode_ctl #(.IVL_W(IVL_W)) u_mode (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .mode_wr_i(mode_wr),
    .ivl_wr_i (ivl_wr),
    .mode_o   (mode),
    .ivl_o    (ivl),
    .cfg_chg_o(cfg_chg)
  );

  assign clr = svc || cfg_chg;

  wdt_counter #(
    .IVL_W     (IVL_W),
    .BASE_SHIFT(BASE_SHIFT),
    .STEP_SHIFT(STEP_SHIFT),
    .CNT_W     (CNT_W)
  ) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .mode_i   (mode),
    .ivl_i    (ivl),
    .clr_i    (clr),
    .wdt_rst_o(wdt_rst_o),
    .tmr_irq_o(tmr_irq_o)
  );
endmodule

// File: tb/wdt_dual_bench.sv
`timescale 1ns/1ps
module wdt_dual_bench;
  logic       clk = 1'b0;
  logic       rst_n, tick, wr_en;
  logic [7:0] wr_data;
  logic       wdt_rst, tmr_irq;
  int cyc = 0, checks = 0, errors = 0, last_wr = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdt_dual u_wdt_dual (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .wdt_rst_o(wdt_rst), .tmr_irq_o(tmr_irq)
  );

  function automatic int lim_of(input int sel);
    return 1 << (3 + 2 * sel);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    last_wr = cyc;
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic quiet(input int n, input string req);
    bit seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (wdt_rst || tmr_irq) seen = 1;
    end
    chk(!seen, req, seen, 0);
  endtask

  // pulse must appear exactly after posedge number exp_edge, for one cycle
  task automatic expect_pulse(input bit is_rst, input int exp_edge, input string req);
    bit early = 0, other = 0, hi = 0;
    while (cyc <= exp_edge) begin
      if (cyc < exp_edge && (is_rst ? wdt_rst : tmr_irq)) early = 1;
      if (is_rst ? tmr_irq : wdt_rst) other = 1;
      if (cyc == exp_edge) hi = is_rst ? wdt_rst : tmr_irq;
      @(negedge clk);
    end
    chk(!early, {req, " early pulse"}, early, 0);
    chk(hi, {req, " pulse at due edge"}, hi, 1);
    chk(!(is_rst ? wdt_rst : tmr_irq), {req, " one-cycle width"}, 1, 0);
    chk(!other, {req, " other output quiet"}, other, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int e;
    rst_n = 1'b0; tick = 1'b1; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    chk(!wdt_rst && !tmr_irq, "R1 outputs low in reset", wdt_rst | tmr_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    quiet(600, "R1 idle after reset");

    wr(8'h04); // mode 01
    quiet(600, "R2 mode 01 idle");
    wr(8'h03); // mode 00, interval 3
    quiet(600, "R2 mode 00 idle");

    // timer sweep over all intervals
    for (int sel = 0; sel < 4; sel++) begin
      wr({4'h0, 2'b11, 2'(sel)});
      e = last_wr;
      expect_pulse(1'b0, e + lim_of(sel), $sformatf("R10 R3 sel%0d first", sel));
      expect_pulse(1'b0, e + 2 * lim_of(sel), $sformatf("R3 sel%0d period", sel));
    end

    // tick gating
    tick = 1'b0;
    wr(8'h0D); // timer, sel1
    quiet(200, "R9 no ticks no expiry");
    tick = 1'b1;
    e = cyc;
    expect_pulse(1'b0, e + lim_of(1), "R9 resume after ticks");

    // stop and restart timer
    wr(8'h0C);
    repeat (5) @(negedge clk);
    wr(8'h00);
    quiet(100, "R8 timer stopped");
    wr(8'h0C);
    expect_pulse(1'b0, last_wr + lim_of(0), "R8 timer restart from zero");

    // reset, then watchdog
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!wdt_rst && !tmr_irq, "R1 outputs low in second reset", wdt_rst | tmr_irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    wr(8'h09); // watchdog, sel1
    e = last_wr;
    expect_pulse(1'b1, e + 32, "R4 first expiry");
    expect_pulse(1'b1, e + 64, "R4 restart after expiry");
    wr(8'h00);
    wr(8'h0F);
    expect_pulse(1'b1, e + 96, "R7 mode and interval locked");
    wr(8'hA9);
    wr(8'h09);
    wr(8'h59);
    expect_pulse(1'b1, e + 128, "R6 broken key sequence");
    wr(8'h59);
    expect_pulse(1'b1, e + 160, "R6 lone fire key");
    wr(8'hA9);
    wr(8'h59);
    e = last_wr;
    expect_pulse(1'b1, e + 32, "R5 service restarts count");
    wr(8'hA9);
    wr(8'hA9);
    wr(8'h59);
    e = last_wr;
    expect_pulse(1'b1, e + 32, "R5 repeated arm then fire");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule